// File: doc/BRIEF.md
# Seconds Counter with Alarm Compare

This block keeps the time of a real-time clock as a single 32-bit count of seconds. A one-cycle pulse arriving once per second on `tick_i` advances the count while the counter is switched on. Software reads and writes a small bank of 32-bit registers through a plain port. One cycle with the write strobe high writes a register, and the read data always shows the register picked by the current address. Through this bank software sets the time, reads the live count, arms a single alarm, and handles the alarm interrupt through mask, clear and status bits. A control bit chooses the clock source for the tick. This block only stores that bit and drives it to an output for the divider that lies outside it.

The build parameter `GRAY_STORE` sets how the count and the alarm are held. When it is 1, the count and the alarm are held in Gray code. Software writes and reads Gray-coded words, and every tick moves the count by one binary step. When it is 0, plain binary is used throughout. The alarm is compared in the same coding the count is stored in. An alarm event latches a status bit. That bit drives the interrupt line only while the alarm is armed and the mask bit is clear.

Top module: `rtc_seconds_top`

## Requirements
- R1: After reset the control word reads 0, the mask reads 1, the status reads 0, the live count reads 0 and `irq_o` is 0.
- R2: Registers sit at these byte offsets: control 0x00, time load 0x04, alarm 0x08, mask 0x20, clear 0x24, status 0x30, live time 0x34. In the control word, bit 0 arms the alarm, bit 8 picks the clock source and drives `clk_sel_o`, and bit 12 switches the counter on. The alarm register reads back the value last written to it.
- R3: With control bit 12 set, each `tick_i` pulse advances the count by one. With bit 12 clear, ticks leave the count unchanged.
- R4: A write to the time load offset replaces the count at the next clock edge, whether or not the counter is on. A tick in the same cycle as the load is dropped.
- R5: With `GRAY_STORE`=1, the words written and read for the count and the alarm are Gray code (g = b ^ (b>>1)), and each tick moves the count one binary step. With `GRAY_STORE`=0 they are plain binary.
- R6: The count covers the whole unsigned 32-bit range and wraps from its largest value to 0.
- R7: Status bit 0 sets on the tick that brings the count equal to the alarm value, but only while control bit 0 is 1. Once set, it stays set. A load does not trigger the compare.
- R8: `irq_o` is high exactly when the status bit is 1, control bit 0 is 1 and mask bit 0 is 0.
- R9: Writing 1 to bit 0 of the clear offset clears the status bit, and writing 0 there has no effect. If a clear and a new alarm match fall in the same cycle, the status bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle pulse per second |
| reg_wr_i | input | 1 | Write strobe for the register port |
| reg_addr_i | input | 6 | Byte offset of the selected register |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data of the addressed register |
| clk_sel_o | output | 1 | Clock-source select (control bit 8) |
| irq_o | output | 1 | Alarm interrupt line |

## Verification
Two pairs of functions can meet in a single cycle. A time-load write can arrive together with a tick, and an interrupt clear can arrive on the very tick that produces an alarm match. The bench sets up each collision by driving the write strobe and `tick_i` in the same cycle. It then reads the live count, which must equal the loaded value with the tick dropped, and the status bit, which must stay set so the new event is not lost. A second instance built in binary mode shares the same stimulus, so each check compares both codings against values the bench computes for itself.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    // Byte offsets of the register bank
    localparam int unsigned OFS_CTRL   = 'h00;
    localparam int unsigned OFS_LOAD   = 'h04;
    localparam int unsigned OFS_ALARM  = 'h08;
    localparam int unsigned OFS_MASK   = 'h20;
    localparam int unsigned OFS_CLEAR  = 'h24;
    localparam int unsigned OFS_STATUS = 'h30;
    localparam int unsigned OFS_LIVE   = 'h34;

    // Control word bit positions
    localparam int unsigned CTL_ALARM_ARM = 0;
    localparam int unsigned CTL_SRC_SEL   = 8;
    localparam int unsigned CTL_RUN       = 12;

    typedef struct packed {
        logic arm;
        logic src_sel;
        logic run;
    } ctrl_bits_t;
endpackage

// File: rtl/rtc_code_conv.sv
module rtc_code_conv #(
    parameter int unsigned WIDTH      = 32,
    parameter bit          GRAY_STORE = 1'b1
) (
    input  logic [WIDTH-1:0] enc_i,   // stored coding
    output logic [WIDTH-1:0] bin_o,   // decoded binary
    input  logic [WIDTH-1:0] bin_i,   // binary to encode
    output logic [WIDTH-1:0] enc_o    // encoded result
);
    generate
        if (GRAY_STORE) begin : g_gray
            for (genvar i = 0; i < WIDTH; i++) begin : g_bit
                assign bin_o[i] = ^enc_i[WIDTH-1:i];
            end
            assign enc_o = bin_i ^ (bin_i >> 1);
        end else begin : g_plain
            assign bin_o = enc_i;
            assign enc_o = bin_i;
        end
    endgenerate
endmodule

// File: rtl/rtc_sec_counter.sv
module rtc_sec_counter #(
    parameter int unsigned WIDTH      = 32,
    parameter bit          GRAY_STORE = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             run_i,
    input  logic             load_i,
    input  logic [WIDTH-1:0] load_val_i,
    output logic [WIDTH-1:0] cnt_o,      // stored coding
    output logic [WIDTH-1:0] next_o,     // stored coding of count+1
    output logic             step_o      // increment happens this cycle
);
    typedef struct packed {
        logic [WIDTH-1:0] cnt;
    } cnt_state_t;

    cnt_state_t       st_d, st_q;
    logic [WIDTH-1:0] cur_bin;
    logic [WIDTH-1:0] inc_bin;
    logic [WIDTH-1:0] inc_enc;

    rtc_code_conv #(.WIDTH(WIDTH), .GRAY_STORE(GRAY_STORE)) i_conv (
        .enc_i (st_q.cnt),
        .bin_o (cur_bin),
        .bin_i (inc_bin),
        .enc_o (inc_enc)
    );

    assign inc_bin = cur_bin + WIDTH'(1);

    always_comb begin
        st_d   = st_q;
        step_o = tick_i && run_i && !load_i;
        if (load_i) begin
            st_d.cnt = load_val_i;
        end else if (step_o) begin
            st_d.cnt = inc_enc;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o  = st_q.cnt;
    assign next_o = inc_enc;

    a_r3_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !load_i) |=> $stable(cnt_o));

    a_r4_load_value: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (cnt_o == $past(load_val_i)));

    a_r5_one_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && run_i && !load_i) |=> (cur_bin == WIDTH'($past(cur_bin) + WIDTH'(1))));
endmodule

// File: rtl/rtc_alarm_irq.sv
module rtc_alarm_irq #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    input  logic [WIDTH-1:0] next_i,
    input  logic [WIDTH-1:0] alarm_i,
    input  logic             arm_i,
    input  logic             mask_i,
    input  logic             clear_i,
    output logic             status_o,
    output logic             irq_o
);
    typedef struct packed {
        logic status;
    } alm_state_t;

    alm_state_t st_d, st_q;
    logic       hit;

    always_comb begin
        st_d = st_q;
        hit  = step_i && arm_i && (next_i == alarm_i);
        if (clear_i) begin
            st_d.status = 1'b0;
        end
        if (hit) begin
            st_d.status = 1'b1;   // a new event wins over a clear
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign status_o = st_q.status;
    assign irq_o    = st_q.status && arm_i && !mask_i;

    a_r9_fall_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status_o) |-> $past(clear_i));

    a_r7_rise_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_o) |-> $past(step_i && arm_i));
endmodule

// File: rtl/rtc_reg_bank.sv
module rtc_reg_bank
    import rtc_pkg::*;
#(
    parameter int unsigned WIDTH  = 32,
    parameter int unsigned ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [WIDTH-1:0]  wdata_i,
    input  logic [WIDTH-1:0]  cnt_i,
    input  logic              status_i,
    output logic [WIDTH-1:0]  rdata_o,
    output ctrl_bits_t        ctrl_o,
    output logic              mask_o,
    output logic [WIDTH-1:0]  alarm_o,
    output logic              load_o,
    output logic              clear_o
);
    typedef struct packed {
        ctrl_bits_t       ctrl;
        logic             mask;
        logic [WIDTH-1:0] alarm;
    } bank_state_t;

    bank_state_t st_d, st_q;
    logic sel_ctrl, sel_load, sel_alarm, sel_mask, sel_clear, sel_status, sel_live;

    always_comb begin
        sel_ctrl   = (addr_i == ADDR_W'(OFS_CTRL));
        sel_load   = (addr_i == ADDR_W'(OFS_LOAD));
        sel_alarm  = (addr_i == ADDR_W'(OFS_ALARM));
        sel_mask   = (addr_i == ADDR_W'(OFS_MASK));
        sel_clear  = (addr_i == ADDR_W'(OFS_CLEAR));
        sel_status = (addr_i == ADDR_W'(OFS_STATUS));
        sel_live   = (addr_i == ADDR_W'(OFS_LIVE));

        st_d    = st_q;
        load_o  = wr_i && sel_load;
        clear_o = wr_i && sel_clear && wdata_i[0];
        if (wr_i && sel_ctrl) begin
            st_d.ctrl.arm     = wdata_i[CTL_ALARM_ARM];
            st_d.ctrl.src_sel = wdata_i[CTL_SRC_SEL];
            st_d.ctrl.run     = wdata_i[CTL_RUN];
        end
        if (wr_i && sel_alarm) begin
            st_d.alarm = wdata_i;
        end
        if (wr_i && sel_mask) begin
            st_d.mask = wdata_i[0];
        end

        rdata_o = '0;
        if (sel_ctrl) begin
            rdata_o[CTL_ALARM_ARM] = st_q.ctrl.arm;
            rdata_o[CTL_SRC_SEL]   = st_q.ctrl.src_sel;
            rdata_o[CTL_RUN]       = st_q.ctrl.run;
        end
        if (sel_load || sel_live) begin
            rdata_o = cnt_i;
        end
        if (sel_alarm) begin
            rdata_o = st_q.alarm;
        end
        if (sel_mask) begin
            rdata_o[0] = st_q.mask;
        end
        if (sel_status) begin
            rdata_o[0] = status_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.ctrl  <= '0;
            st_q.mask  <= 1'b1;
            st_q.alarm <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl_o  = st_q.ctrl;
    assign mask_o  = st_q.mask;
    assign alarm_o = st_q.alarm;

    a_r2_alarm_kept: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_i && sel_alarm) |=> $stable(alarm_o));
endmodule

// File: rtl/rtc_seconds_top.sv
module rtc_seconds_top
    import rtc_pkg::*;
#(
    parameter int unsigned WIDTH      = 32,
    parameter int unsigned ADDR_W     = 6,
    parameter bit          GRAY_STORE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              reg_wr_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [WIDTH-1:0]  reg_wdata_i,
    output logic [WIDTH-1:0]  reg_rdata_o,
    output logic              clk_sel_o,
    output logic              irq_o
);
    ctrl_bits_t       ctrl;
    logic             mask;
    logic [WIDTH-1:0] alarm_val;
    logic             load_stb;
    logic             clear_stb;
    logic [WIDTH-1:0] cnt;
    logic [WIDTH-1:0] cnt_next;
    logic             step;
    logic             status;

    rtc_reg_bank #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) i_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (reg_wr_i),
        .addr_i   (reg_addr_i),
        .wdata_i  (reg_wdata_i),
        .cnt_i    (cnt),
        .status_i (status),
        .rdata_o  (reg_rdata_o),
        .ctrl_o   (ctrl),
        .mask_o   (mask),
        .alarm_o  (alarm_val),
        .load_o   (load_stb),
        .clear_o  (clear_stb)
    );

    rtc_sec_counter #(.WIDTH(WIDTH), .GRAY_STORE(GRAY_STORE)) i_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_i),
        .run_i      (ctrl.run),
        .load_i     (load_stb),
        .load_val_i (reg_wdata_i),
        .cnt_o      (cnt),
        .next_o     (cnt_next),
        .step_o     (step)
    );

    rtc_alarm_irq #(.WIDTH(WIDTH)) i_alarm (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_i   (step),
        .next_i   (cnt_next),
        .alarm_i  (alarm_val),
        .arm_i    (ctrl.arm),
        .mask_i   (mask),
        .clear_i  (clear_stb),
        .status_o (status),
        .irq_o    (irq_o)
    );

    assign clk_sel_o = ctrl.src_sel;

    a_r8_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && (reg_addr_i == ADDR_W'(OFS_MASK)) && reg_wdata_i[0]) |=> !irq_o);
endmodule

// File: tb/test_rtc_seconds_top.sv
module test_rtc_seconds_top;
    localparam logic [5:0] A_CTRL = 6'h00, A_LOAD = 6'h04, A_ALARM = 6'h08,
                           A_MASK = 6'h20, A_CLR = 6'h24, A_STAT = 6'h30, A_LIVE = 6'h34;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        wr = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata_g, rdata_b;
    logic        clk_sel_g, clk_sel_b, irq_g, irq_b;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    typedef struct {
        int          kind;   // 0 gray rdata, 1 binary rdata, 2 gray irq, 3 clock select
        logic [31:0] exp;
        string       req;
    } item_t;
    item_t sb[$];

    always #4 clk = ~clk;

    rtc_seconds_top #(.GRAY_STORE(1'b1)) i_rtc_seconds_top (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .reg_wr_i(wr), .reg_addr_i(addr),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata_g), .clk_sel_o(clk_sel_g), .irq_o(irq_g));

    rtc_seconds_top #(.GRAY_STORE(1'b0)) i_rtc_seconds_top_bin (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .reg_wr_i(wr), .reg_addr_i(addr),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata_b), .clk_sel_o(clk_sel_b), .irq_o(irq_b));

    function automatic logic [31:0] b2g(logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    task automatic drive(bit w, logic [5:0] a, logic [31:0] d, bit t);
        @(posedge clk);
        #2;
        wr = w; addr = a; wdata = d; tick = t;
    endtask

    task automatic rd(logic [5:0] a);
        drive(1'b0, a, 32'h0, 1'b0);
    endtask

    task automatic expect_item(int kind, logic [31:0] exp, string req);
        item_t it;
        it.kind = kind; it.exp = exp; it.req = req;
        sb.push_back(it);
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) drive(1'b0, A_LIVE, 32'h0, 1'b1);
    endtask

    // Monitor: compare every queued expectation away from the active edge
    initial begin
        forever begin
            @(negedge clk);
            while (sb.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = sb.pop_front();
                case (it.kind)
                    0: act = rdata_g;
                    1: act = rdata_b;
                    2: act = {31'h0, irq_g};
                    default: act = {31'h0, clk_sel_g};
                endcase
                n_run++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;

        // R1 reset state
        rd(A_CTRL); expect_item(0, 32'h0, "R1 ctrl");
        rd(A_MASK); expect_item(0, 32'h1, "R1 mask");
        rd(A_STAT); expect_item(0, 32'h0, "R1 status"); expect_item(2, 32'h0, "R1 irq");
        rd(A_LIVE); expect_item(0, 32'h0, "R1 live"); expect_item(1, 32'h0, "R1 live bin");

        // R3 ticks ignored while switched off
        ticks(3);
        rd(A_LIVE); expect_item(0, 32'h0, "R3 hold"); expect_item(1, 32'h0, "R3 hold bin");

        // R3/R5 counting in both codings
        drive(1'b1, A_CTRL, 32'h1000, 1'b0);
        drive(1'b1, A_LOAD, b2g(32'd100), 1'b0);
        ticks(5);
        rd(A_LIVE); expect_item(0, b2g(32'd105), "R5 gray count");
        expect_item(1, b2g(32'd100) + 32'd5, "R3 binary count");

        // R4 load beats a tick in the same cycle
        drive(1'b1, A_LOAD, b2g(32'd500), 1'b1);
        rd(A_LIVE); expect_item(0, b2g(32'd500), "R4 load priority");
        expect_item(1, b2g(32'd500), "R4 load priority bin");

        // R7/R8 alarm
        drive(1'b1, A_ALARM, b2g(32'd503), 1'b0);
        drive(1'b1, A_CTRL, 32'h1001, 1'b0);
        drive(1'b1, A_MASK, 32'h0, 1'b0);
        rd(A_ALARM); expect_item(0, b2g(32'd503), "R2 alarm readback");
        ticks(2);
        rd(A_STAT); expect_item(0, 32'h0, "R7 not yet"); expect_item(2, 32'h0, "R8 idle");
        ticks(1);
        rd(A_STAT); expect_item(0, 32'h1, "R7 match"); expect_item(2, 32'h1, "R8 raised");
        ticks(1);
        rd(A_STAT); expect_item(0, 32'h1, "R7 sticky");

        // R9 clear
        drive(1'b1, A_CLR, 32'h0, 1'b0);
        rd(A_STAT); expect_item(0, 32'h1, "R9 zero write ignored");
        drive(1'b1, A_CLR, 32'h1, 1'b0);
        rd(A_STAT); expect_item(0, 32'h0, "R9 cleared"); expect_item(2, 32'h0, "R9 irq low");

        // R8 mask gating
        drive(1'b1, A_MASK, 32'h1, 1'b0);
        drive(1'b1, A_LOAD, b2g(32'd600), 1'b0);
        drive(1'b1, A_ALARM, b2g(32'd601), 1'b0);
        ticks(1);
        rd(A_STAT); expect_item(0, 32'h1, "R8 status under mask"); expect_item(2, 32'h0, "R8 masked");
        drive(1'b1, A_MASK, 32'h0, 1'b0);
        rd(A_STAT); expect_item(2, 32'h1, "R8 unmasked");
        drive(1'b1, A_CLR, 32'h1, 1'b0);

        // R6 wrap, R7 disarmed alarm at 0 never fires
        drive(1'b1, A_CTRL, 32'h1000, 1'b0);
        drive(1'b1, A_ALARM, 32'h0, 1'b0);
        drive(1'b1, A_LOAD, 32'h8000_0000, 1'b0);
        ticks(1);
        rd(A_LIVE); expect_item(0, 32'h0, "R6 gray wrap"); expect_item(1, 32'h8000_0001, "R6 bin step");
        rd(A_STAT); expect_item(0, 32'h0, "R7 disarmed"); expect_item(2, 32'h0, "R8 disarmed");
        drive(1'b1, A_LOAD, 32'hFFFF_FFFF, 1'b0);
        ticks(1);
        rd(A_LIVE); expect_item(1, 32'h0, "R6 bin wrap");
        expect_item(0, b2g(32'hAAAA_AAAB), "R6 gray from all ones");

        // R9 clear and match together: set wins
        drive(1'b1, A_CTRL, 32'h1001, 1'b0);
        drive(1'b1, A_LOAD, b2g(32'd700), 1'b0);
        drive(1'b1, A_ALARM, b2g(32'd701), 1'b0);
        drive(1'b1, A_CLR, 32'h1, 1'b1);
        rd(A_STAT); expect_item(0, 32'h1, "R9 set beats clear"); expect_item(2, 32'h1, "R9 irq kept");
        drive(1'b1, A_CLR, 32'h1, 1'b0);
        rd(A_STAT); expect_item(0, 32'h0, "R9 final clear");

        // R2 clock source bit
        drive(1'b1, A_CTRL, 32'h1101, 1'b0);
        rd(A_CTRL); expect_item(0, 32'h1101, "R2 ctrl readback"); expect_item(3, 32'h1, "R2 clk select");

        drive(1'b0, A_LIVE, 32'h0, 1'b0);
        @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule